// File: doc/BRIEF.md
# Layer Priority and Intensity Mixer

This block composites one display pixel per clock for a tile-based video engine. At each pixel four candidates arrive: a background tile plane, a foreground tile plane, a window plane that can take the foreground plane's place, and the sprite layer. Each candidate carries a 4-bit colour index, a 2-bit palette line and a priority bit. The mixer picks the visible candidate under a fixed nine-level ranking. It turns the winner's palette line and index into a 6-bit address into a 64-entry colour store, reads a 9-bit colour, and outputs three 4-bit channels.

An optional intensity mode gives every pixel one of three levels: shadowed, normal or highlighted. The base level comes from the tile priority bits. Two reserved sprite colours are not drawn; each one moves the intensity of the pixel beneath it up or down by one step. A configurable backdrop fills the pixel wherever no layer is opaque. The backdrop is also forced while the display is disabled and, when left-edge blanking is on, over the first columns of each line.

The pipeline has two register stages. The first registers the colour-store address and the intensity level. The second registers the converted RGB pixel. The colour store is loaded through a simple write port.

Top module: `pix_layer_mixer`

## Requirements
- R1: After reset all three output channels are 0, and the colour store holds 0 in every entry.
- R2: A layer candidate whose colour index is 0 is transparent for every palette line, and selection falls through to the next lower rank.
- R3: Ranks from highest to lowest: high-priority window, high-priority sprite, high-priority foreground, high-priority background, low-priority window, low-priority sprite, low-priority foreground, low-priority background, backdrop. The highest-ranked opaque candidate is shown.
- R4: While `win_on` is 1, the window candidate takes the foreground candidate's place and the foreground input has no effect on the pixel or its intensity. While `win_on` is 0, the window input is ignored.
- R5: The backdrop address is `bg_sel`: bits 5..4 give the palette line and bits 3..0 give the entry. Entry 0 is a legal backdrop.
- R6: The colour-store address is palette line × 16 + index. A stored word keeps red from bits 3..1, green from bits 7..5 and blue from bits 11..9 of `pal_word`. Bits 0, 4, 8 and 15..12 are ignored.
- R7: When `left_blank` is 1 and `pix_x` < 8, the pixel shows the backdrop at normal intensity.
- R8: When `disp_en` is 0, every pixel shows the backdrop at normal intensity.
- R9: When `sh_en` is 0, every pixel has normal intensity. When `sh_en` is 1, the base intensity is normal if the priority bit of the background tile or of the foreground/window tile is 1, and shadowed otherwise.
- R10: When `sh_en` is 1, a sprite with palette line 3 and index 14 is not drawn and raises the intensity one step (shadow to normal, normal to highlight). When `sh_en` is 0, the same sprite is drawn as an ordinary colour.
- R11: When `sh_en` is 1, a sprite with palette line 3 and index 15 is not drawn and lowers the intensity one step (highlight to normal, normal to shadow). A shadowed pixel stays shadowed.
- R12: A 3-bit component c gives the 4-bit channel {c,0} at normal intensity, {0,c} when shadowed and {1,c} when highlighted. The result appears on the outputs two rising clock edges after the inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_en | input | 1 | Display enable; 0 forces the backdrop |
| left_blank | input | 1 | Force the backdrop over the leftmost 8 columns |
| sh_en | input | 1 | Three-level intensity mode enable |
| bg_sel | input | 6 | Backdrop palette line (5..4) and entry (3..0) |
| pix_x | input | 9 | Column of the current pixel |
| plane_b | input | 7 | Background tile candidate {prio, pal[1:0], idx[3:0]} |
| plane_a | input | 7 | Foreground tile candidate {prio, pal[1:0], idx[3:0]} |
| win_on | input | 1 | Window covers this pixel |
| win_px | input | 7 | Window candidate {prio, pal[1:0], idx[3:0]} |
| spr_px | input | 7 | Sprite candidate {prio, pal[1:0], idx[3:0]} |
| pal_we | input | 1 | Colour-store write enable |
| pal_addr | input | 6 | Colour-store write address |
| pal_word | input | 16 | Colour word to store |
| rgb_r | output | 4 | Red channel |
| rgb_g | output | 4 | Green channel |
| rgb_b | output | 4 | Blue channel |

## Verification
On every cycle the assertions check the forcing rules: with the display off or inside the blanked left columns, the registered address must be the previous cycle's backdrop at normal intensity. They also check that intensity stays normal with the mode off, and that each intensity level leaves its fixed bit pattern on the output channels. The layer ranking, window substitution, transparency fall-through, colour field extraction and the operator sprites are shown only by the bench's sweeps. Those sweeps cover every combination of opacity, priority and window state, with and without the intensity mode, and every colour-store entry.

// File: rtl/pxm_pkg.sv
package pxm_pkg;
    localparam int IDX_W  = 4;
    localparam int PAL_W  = 2;
    localparam int COMP_W = 3;
    localparam int CH_W   = COMP_W + 1;
    localparam int ADDR_W = PAL_W + IDX_W;
    localparam int WORD_W = 16;
    localparam int NCH    = 3;
    localparam int PX_W   = 1 + PAL_W + IDX_W;

    typedef struct packed {
        logic              prio;
        logic [PAL_W-1:0]  pal;
        logic [IDX_W-1:0]  idx;
    } layer_px_t;

    typedef enum logic [1:0] {
        SH_DARK   = 2'd0,
        SH_NORM   = 2'd1,
        SH_BRIGHT = 2'd2
    } shade_e;

    typedef struct packed {
        logic [COMP_W-1:0] b;
        logic [COMP_W-1:0] g;
        logic [COMP_W-1:0] r;
    } color_t;
endpackage

// File: rtl/pxm_layer_sel.sv
module pxm_layer_sel
    import pxm_pkg::*;
#(
    parameter int X_W       = 9,
    parameter int LEFT_COLS = 8
) (
    input  logic              disp_en,
    input  logic              left_blank,
    input  logic              sh_en,
    input  logic [X_W-1:0]    pix_x,
    input  logic [ADDR_W-1:0] bg_sel,
    input  layer_px_t         b_px,
    input  layer_px_t         a_px,
    input  logic              win_on,
    input  layer_px_t         w_px,
    input  layer_px_t         s_px,
    output logic [ADDR_W-1:0] addr,
    output shade_e            shade
);
    localparam int NLAY  = 4;
    localparam int NCAND = 2 * NLAY;
    localparam logic [IDX_W-1:0] IDX_TOP = '1;
    localparam logic [PAL_W-1:0] PAL_TOP = '1;

    layer_px_t         lay  [NLAY];
    logic [NLAY-1:0]   vis;
    logic [NCAND-1:0]  hit;
    logic [ADDR_W-1:0] pick [NCAND];
    logic              op_up, op_down, blank, tile_pri;

    // rank order inside one priority class: background, foreground, sprite, window
    assign lay[0] = b_px;
    assign lay[1] = a_px;
    assign lay[2] = s_px;
    assign lay[3] = w_px;

    assign op_up   = sh_en && (s_px.pal == PAL_TOP) && (s_px.idx == IDX_TOP - 1'b1);
    assign op_down = sh_en && (s_px.pal == PAL_TOP) && (s_px.idx == IDX_TOP);

    assign vis[0] = (b_px.idx != '0);
    assign vis[1] = !win_on && (a_px.idx != '0);
    assign vis[2] = (s_px.idx != '0) && !op_up && !op_down;
    assign vis[3] = win_on && (w_px.idx != '0);

    for (genvar p = 0; p < 2; p++) begin : g_pri
        for (genvar l = 0; l < NLAY; l++) begin : g_lay
            assign hit[p*NLAY + l]  = vis[l] && (lay[l].prio == 1'(p));
            assign pick[p*NLAY + l] = {lay[l].pal, lay[l].idx};
        end
    end

    assign blank    = !disp_en || (left_blank && (pix_x < X_W'(LEFT_COLS)));
    assign tile_pri = b_px.prio || (win_on ? w_px.prio : a_px.prio);

    always_comb begin
        addr  = bg_sel;
        shade = SH_NORM;
        if (!blank) begin
            for (int k = 0; k < NCAND; k++) begin
                if (hit[k]) addr = pick[k];
            end
            if (sh_en) begin
                shade = tile_pri ? SH_NORM : SH_DARK;
                if (op_up) begin
                    shade = (shade == SH_DARK) ? SH_NORM : SH_BRIGHT;
                end else if (op_down) begin
                    shade = (shade == SH_BRIGHT) ? SH_NORM : SH_DARK;
                end
            end
        end
    end
endmodule

// File: rtl/pxm_color_ram.sv
module pxm_color_ram
    import pxm_pkg::*;
#(
    parameter int ENTRIES = 2 ** ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wword,
    input  logic [ADDR_W-1:0] raddr,
    output color_t            rdata
);
    localparam int R_LSB = 1;
    localparam int G_LSB = 5;
    localparam int B_LSB = 9;

    color_t mem_d [ENTRIES];
    color_t mem_q [ENTRIES];
    logic   unused_bits;

    assign unused_bits = ^{wword[WORD_W-1:B_LSB+COMP_W], wword[G_LSB+COMP_W],
                           wword[R_LSB+COMP_W], wword[0]};

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[waddr] = '{b: wword[B_LSB +: COMP_W],
                             g: wword[G_LSB +: COMP_W],
                             r: wword[R_LSB +: COMP_W]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/pxm_shade.sv
module pxm_shade
    import pxm_pkg::*;
(
    input  color_t                col,
    input  shade_e                shade,
    output logic [NCH*CH_W-1:0]   rgb
);
    logic [NCH*COMP_W-1:0] comps;
    assign comps = col;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [COMP_W-1:0] c;
        logic [CH_W-1:0]   v;
        assign c = comps[ch*COMP_W +: COMP_W];
        always_comb begin
            case (shade)
                SH_DARK:   v = {1'b0, c};
                SH_BRIGHT: v = {1'b1, c};
                default:   v = {c, 1'b0};
            endcase
        end
        // component 0 is red and lands in the top field
        assign rgb[(NCH-1-ch)*CH_W +: CH_W] = v;
    end
endmodule

// File: rtl/pix_layer_mixer.sv
module pix_layer_mixer
    import pxm_pkg::*;
#(
    parameter int X_W       = 9,
    parameter int LEFT_COLS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_en,
    input  logic              left_blank,
    input  logic              sh_en,
    input  logic [5:0]        bg_sel,
    input  logic [X_W-1:0]    pix_x,
    input  logic [6:0]        plane_b,
    input  logic [6:0]        plane_a,
    input  logic              win_on,
    input  logic [6:0]        win_px,
    input  logic [6:0]        spr_px,
    input  logic              pal_we,
    input  logic [5:0]        pal_addr,
    input  logic [15:0]       pal_word,
    output logic [3:0]        rgb_r,
    output logic [3:0]        rgb_g,
    output logic [3:0]        rgb_b
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        shade_e            shade;
    } sel_t;

    typedef struct packed {
        sel_t                sel;
        logic [NCH*CH_W-1:0] rgb;
    } pipe_t;

    pipe_t               pipe_d, pipe_q;
    logic [ADDR_W-1:0]   sel_addr;
    shade_e              sel_shade;
    color_t              rd_col;
    logic [NCH*CH_W-1:0] shaded;
    logic [ADDR_W-1:0]   st_addr;
    logic [1:0]          st_shade;

    pxm_layer_sel #(.X_W(X_W), .LEFT_COLS(LEFT_COLS)) u_sel (
        .disp_en    (disp_en),
        .left_blank (left_blank),
        .sh_en      (sh_en),
        .pix_x      (pix_x),
        .bg_sel     (bg_sel),
        .b_px       (layer_px_t'(plane_b)),
        .a_px       (layer_px_t'(plane_a)),
        .win_on     (win_on),
        .w_px       (layer_px_t'(win_px)),
        .s_px       (layer_px_t'(spr_px)),
        .addr       (sel_addr),
        .shade      (sel_shade)
    );

    pxm_color_ram u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (pal_we),
        .waddr (pal_addr),
        .wword (pal_word),
        .raddr (pipe_q.sel.addr),
        .rdata (rd_col)
    );

    pxm_shade u_shade (
        .col   (rd_col),
        .shade (pipe_q.sel.shade),
        .rgb   (shaded)
    );

    always_comb begin
        pipe_d           = pipe_q;
        pipe_d.sel.addr  = sel_addr;
        pipe_d.sel.shade = sel_shade;
        pipe_d.rgb       = shaded;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '{sel: '{addr: '0, shade: SH_NORM}, rgb: '0};
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign st_addr  = pipe_q.sel.addr;
    assign st_shade = pipe_q.sel.shade;
    assign rgb_r    = pipe_q.rgb[2*CH_W +: CH_W];
    assign rgb_g    = pipe_q.rgb[CH_W +: CH_W];
    assign rgb_b    = pipe_q.rgb[0 +: CH_W];
endmodule

// File: rtl/pxm_checker.sv
module pxm_checker #(
    parameter int X_W       = 9,
    parameter int LEFT_COLS = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           disp_en,
    input logic           left_blank,
    input logic           sh_en,
    input logic [X_W-1:0] pix_x,
    input logic [5:0]     bg_sel,
    input logic [5:0]     st_addr,
    input logic [1:0]     st_shade,
    input logic [3:0]     rgb_r,
    input logic [3:0]     rgb_g,
    input logic [3:0]     rgb_b
);
    p_disp_off_bg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_en |=> (st_addr == $past(bg_sel)) && (st_shade == 2'd1));

    p_left_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (left_blank && (pix_x < X_W'(LEFT_COLS))) |=> (st_addr == $past(bg_sel)) && (st_shade == 2'd1));

    p_sh_off_normal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_en |=> (st_shade == 2'd1));

    p_shade_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_shade != 2'd3);

    p_normal_lsb_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_shade == 2'd1) |=> !rgb_r[0] && !rgb_g[0] && !rgb_b[0]);

    p_dark_msb_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_shade == 2'd0) |=> !rgb_r[3] && !rgb_g[3] && !rgb_b[3]);

    p_bright_msb_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_shade == 2'd2) |=> rgb_r[3] && rgb_g[3] && rgb_b[3]);
endmodule

bind pix_layer_mixer pxm_checker #(.X_W(X_W), .LEFT_COLS(LEFT_COLS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .disp_en    (disp_en),
    .left_blank (left_blank),
    .sh_en      (sh_en),
    .pix_x      (pix_x),
    .bg_sel     (bg_sel),
    .st_addr    (st_addr),
    .st_shade   (st_shade),
    .rgb_r      (rgb_r),
    .rgb_g      (rgb_g),
    .rgb_b      (rgb_b)
);

// File: tb/pix_layer_mixer_test.sv
module pix_layer_mixer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        disp_en = 1'b0, left_blank = 1'b0, sh_en = 1'b0, win_on = 1'b0;
    logic [5:0]  bg_sel = '0;
    logic [8:0]  pix_x = '0;
    logic [6:0]  plane_b = '0, plane_a = '0, win_px = '0, spr_px = '0;
    logic        pal_we = 1'b0;
    logic [5:0]  pal_addr = '0;
    logic [15:0] pal_word = '0;
    logic [3:0]  rgb_r, rgb_g, rgb_b;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    always #5ns clk = ~clk;

    pix_layer_mixer uut (.*);

    // colour pattern loaded into entry e
    function automatic logic [8:0] ent_col(input int e);
        logic [2:0] r, g, b;
        r = 3'(e);
        g = 3'(e >> 3);
        b = 3'(e + 3);
        return {b, g, r};
    endfunction

    function automatic logic [3:0] conv(input logic [2:0] c, input int shd);
        if (shd == 0) return {1'b0, c};
        if (shd == 2) return {1'b1, c};
        return {c, 1'b0};
    endfunction

    function automatic logic [11:0] exp_pix(input logic disp, lb, sh, input int x,
                                            input logic [5:0] bg,
                                            input logic [6:0] b, a, w, s,
                                            input logic won);
        logic [5:0] adr;
        logic [8:0] col;
        int best, shd;
        logic opu, opd;
        adr = bg; shd = 1; best = -1;
        opu = sh && s[5:4] == 2'd3 && s[3:0] == 4'd14;
        opd = sh && s[5:4] == 2'd3 && s[3:0] == 4'd15;
        if (disp && !(lb && x < 8)) begin
            if (b[3:0] != 0 && (b[6] ? 4 : 0) > best) begin best = b[6] ? 4 : 0; adr = b[5:0]; end
            if (!won && a[3:0] != 0 && (a[6] ? 5 : 1) > best) begin best = a[6] ? 5 : 1; adr = a[5:0]; end
            if (s[3:0] != 0 && !opu && !opd && (s[6] ? 6 : 2) > best) begin best = s[6] ? 6 : 2; adr = s[5:0]; end
            if (won && w[3:0] != 0 && (w[6] ? 7 : 3) > best) begin best = w[6] ? 7 : 3; adr = w[5:0]; end
            if (sh) begin
                shd = (b[6] || (won ? w[6] : a[6])) ? 1 : 0;
                if (opu) shd = shd + 1;
                if (opd && shd > 0) shd = shd - 1;
            end
        end
        col = ent_col(int'(adr));
        return {conv(col[2:0], shd), conv(col[5:3], shd), conv(col[8:6], shd)};
    endfunction

    task automatic check(input string tag, input logic [11:0] got, input logic [11:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %03h expected %03h", tag, got, exp);
        end
    endtask

    task automatic run_px(input string tag, input logic disp, lb, sh, input int x,
                          input logic [5:0] bg, input logic [6:0] b, a, w, s,
                          input logic won);
        @(negedge clk);
        disp_en = disp; left_blank = lb; sh_en = sh; pix_x = 9'(x); bg_sel = bg;
        plane_b = b; plane_a = a; win_px = w; spr_px = s; win_on = won;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check(tag, {rgb_r, rgb_g, rgb_b}, exp_pix(disp, lb, sh, x, bg, b, a, w, s, won));
    endtask

    // four opaque flags, four priority flags, window state
    task automatic sweep(input string tag, input logic sh, input logic [6:0] spr_opq);
        for (int m = 0; m < 256; m++) begin
            for (int wn = 0; wn < 2; wn++) begin
                logic [6:0] b, a, w, s;
                b = {m[4], 2'd0, m[0] ? 4'd5 : 4'd0};
                a = {m[5], 2'd1, m[1] ? 4'd6 : 4'd0};
                w = {m[6], 2'd2, m[2] ? 4'd7 : 4'd0};
                s = {m[7], spr_opq[5:0]};
                if (!m[3]) s[3:0] = 4'd0;
                run_px(tag, 1'b1, 1'b0, sh, 40, 6'h2B, b, a, w, s, wn[0]);
            end
        end
    endtask

    initial begin
        #1ms;
        if (!ended) begin
            ended = 1;
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset outputs", {rgb_r, rgb_g, rgb_b}, 12'h000);
        rst_n = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R1 store cleared", {rgb_r, rgb_g, rgb_b}, 12'h000);

        // load every entry, with the unused bits of each word set (R6)
        for (int e = 0; e < 64; e++) begin
            logic [8:0] c;
            c = ent_col(e);
            @(negedge clk);
            pal_we = 1'b1; pal_addr = 6'(e);
            pal_word = {4'hF, c[8:6], 1'b1, c[5:3], 1'b1, c[2:0], 1'b1};
        end
        @(negedge clk);
        pal_we = 1'b0;

        // R2 R3 R4: ranking, transparency and window substitution
        sweep("R3 ranking", 1'b0, {1'b0, 2'd3, 4'd9});

        // R5: every backdrop choice including entry 0
        for (int g = 0; g < 64; g++)
            run_px("R5 backdrop", 1'b1, 1'b0, 1'b0, 50, 6'(g), 7'h10, 7'h20, 7'h30, 7'h70, 1'b0);

        // R6: every addressable non-transparent entry through the background plane
        for (int p = 0; p < 4; p++)
            for (int i = 1; i < 16; i++)
                run_px("R6 colour fields", 1'b1, 1'b0, 1'b0, 60, 6'h00,
                       {1'b0, 2'(p), 4'(i)}, 7'h0, 7'h0, 7'h0, 1'b0);

        // R7: left-edge blanking over columns 0..15, and off at column 3
        for (int x = 0; x < 16; x++)
            run_px("R7 left blank", 1'b1, 1'b1, 1'b1, x, 6'h15, 7'h45, 7'h5A, 7'h0, 7'h3E, 1'b0);
        run_px("R7 blank off", 1'b1, 1'b0, 1'b0, 3, 6'h15, 7'h45, 7'h0, 7'h0, 7'h0, 1'b0);

        // R8: display disabled with opaque layers and an operator sprite
        run_px("R8 display off", 1'b0, 1'b0, 1'b1, 100, 6'h27, 7'h45, 7'h5A, 7'h0, 7'h3F, 1'b0);
        run_px("R8 display off", 1'b0, 1'b0, 1'b0, 200, 6'h09, 7'h45, 7'h5A, 7'h6B, 7'h73, 1'b1);

        // R9 R10 R11: intensity mode with plain, raising and lowering sprites
        sweep("R9 intensity", 1'b1, {1'b0, 2'd2, 4'd9});
        sweep("R10 raise op", 1'b1, {1'b0, 2'd3, 4'd14});
        sweep("R11 lower op", 1'b1, {1'b0, 2'd3, 4'd15});
        run_px("R10 drawn when mode off", 1'b1, 1'b0, 1'b0, 20, 6'h01, 7'h05, 7'h0, 7'h0, 7'h3E, 1'b0);
        run_px("R11 drawn when mode off", 1'b1, 1'b0, 1'b0, 20, 6'h01, 7'h05, 7'h0, 7'h0, 7'h3F, 1'b0);

        // R12: back-to-back pixels, each visible two edges after it was sampled
        begin
            logic [11:0] expq [8];
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (i >= 2) check("R12 latency", {rgb_r, rgb_g, rgb_b}, expq[i-2]);
                if (i < 8) begin
                    disp_en = 1'b1; left_blank = 1'b0; sh_en = i[0]; pix_x = 9'(30 + i);
                    bg_sel = 6'(i); win_on = 1'b0; plane_a = 7'h0; win_px = 7'h0;
                    plane_b = {i[1], 2'(i), 4'(i + 1)};
                    spr_px  = (i == 5) ? 7'h3E : 7'h0;
                    expq[i] = exp_pix(1'b1, 1'b0, i[0], 30 + i, 6'(i), plane_b, 7'h0, 7'h0, spr_px, 1'b0);
                end
            end
        end

        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule